// File: doc/BRIEF.md
# Load Address and Data Formatter

This block executes the register-register load instructions of a 32-bit core. It takes an instruction word and two operand values. It computes the effective address of the load and issues a single read to a simple memory port, with a byte-enable mask for the lanes the load uses. When the read data returns, it cuts out the byte, halfword or word, zero-extends it, and presents it as a writeback to the destination register.

An 11-bit extension field at the low end of the instruction selects one of four variants:

- a plain load;
- a byte-order-reversed load;
- an extended-address load, whose address is the bitwise AND of the operands rather than their sum;
- an exclusive word load, which also sets a reservation flag.

Any other extension pattern, or a non-load major opcode, raises a one-cycle illegal-instruction pulse and starts no memory access. The block holds only one read in flight. It refuses a new instruction until the outstanding read has returned.

Top module: `ldfmt_top`

## Requirements
- R1: During and after synchronous reset, `mem_rd`, `mem_be`, `mem_addr`, `illegal`, `wb_en` and `resv` are 0, and `issue_ready` is 1.
- R2: An instruction is accepted on a rising edge where `issue_valid` and `issue_ready` are both 1. In the cycle after acceptance of a legal load, `mem_rd` is 1 for exactly one cycle and `issue_ready` is 0. `issue_ready` stays 0 until the edge that ends the cycle in which `mem_rvalid` returns.
- R3: Instruction bits [31:26] hold the opcode, [25:21] the destination index, and [10:0] the extension. The extension value 11'h080 makes `mem_addr` equal `ra_val & rb_val`. The values 11'h000, 11'h200 and 11'h400 make it `ra_val + rb_val`. `mem_addr` appears in the cycle `mem_rd` is 1.
- R4: `mem_be[3]` enables data bits [31:24], which is lane 0 (address bits [1:0] = 00), down to `mem_be[0]` for bits [7:0]. A byte load enables its one lane. A halfword load enables 1100 when address bit 1 is 0 and 0011 when it is 1. A word load enables 1111.
- R5: Opcode 6'b110000 loads a byte. The writeback data holds that byte in bits [7:0] and zeros in bits [31:8].
- R6: Opcode 6'b110001 loads a halfword. The writeback data holds the selected halfword in bits [15:0] and zeros above.
- R7: Opcode 6'b110010 loads the full word unchanged.
- R8: A reversed byte load (extension 11'h200) uses the mirrored lane (address bits [1:0] XOR 3), for both its byte enable and its data.
- R9: A reversed halfword or word load swaps the byte order of the loaded value before writeback.
- R10: `wb_en` is 1, with `wb_reg` equal to the destination index, in exactly the cycle `mem_rvalid` is 1 while a read is outstanding. A `mem_rvalid` with no read outstanding gives no writeback.
- R11: A word load with extension 11'h400 writes back the plain word and sets `resv` to 1 at the edge ending its writeback cycle.
- R12: `resv_clr` clears `resv` at the next edge. It takes priority over a reservation set in the same cycle.
- R13: Either of the following gives `illegal` = 1 for one cycle after acceptance, with no `mem_rd`, no writeback, and `issue_ready` remaining 1:
  - an extension other than 11'h000, 11'h200, 11'h080 (byte and halfword only) or 11'h400 (word only);
  - an opcode other than the three loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction and operands are presented |
| issue_ready | output | 1 | Block can accept an instruction |
| instr | input | 32 | Instruction word, bit 31 = opcode MSB |
| ra_val | input | 32 | First operand value |
| rb_val | input | 32 | Second operand value |
| mem_rd | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits [31:24] |
| mem_rdata | input | 32 | Read data, big-endian lanes |
| mem_rvalid | input | 1 | Read data valid |
| wb_en | output | 1 | Destination register write enable |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 32 | Formatted destination value |
| resv_clr | input | 1 | Clears the reservation flag |
| resv | output | 1 | Reservation flag |
| illegal | output | 1 | Unrecognised instruction pulse |

## Verification
The results of an accepted instruction appear one cycle after the accepting edge: the read request with its address and enables, or the illegal pulse. The bench drives each input on a falling edge and samples the following falling edge, so exactly one rising edge lies in between. Writeback is combinational in the cycle `mem_rvalid` is driven, so the bench raises `mem_rvalid` on a falling edge and samples a short delay later, before the next rising edge. The reservation flag and `issue_ready` are read one falling edge after that writeback. Read latency is varied randomly from zero to three idle cycles, and `wb_en` is checked to stay low during those idle cycles.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int INSN_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int EXT_W = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsize_e;

  localparam logic [5:0] OPC_LD_BYTE = 6'b110000;
  localparam logic [5:0] OPC_LD_HALF = 6'b110001;
  localparam logic [5:0] OPC_LD_WORD = 6'b110010;

  localparam logic [EXT_W-1:0] EXT_PLAIN = 11'h000;
  localparam logic [EXT_W-1:0] EXT_SWAP  = 11'h200;
  localparam logic [EXT_W-1:0] EXT_ANDEA = 11'h080;
  localparam logic [EXT_W-1:0] EXT_EXCL  = 11'h400;
endpackage

// File: rtl/ldfmt_decode.sv
module ldfmt_decode
  import ldfmt_pkg::*;
(
  input  logic [5:0]       opcode,
  input  logic [EXT_W-1:0] ext,
  output logic             legal,
  output lsize_e           size,
  output logic             rev,
  output logic             ea,
  output logic             excl
);
  logic is_load;

  always_comb begin
    is_load = 1'b1;
    size    = SZ_WORD;
    case (opcode)
      OPC_LD_BYTE: size = SZ_BYTE;
      OPC_LD_HALF: size = SZ_HALF;
      OPC_LD_WORD: size = SZ_WORD;
      default:     is_load = 1'b0;
    endcase
  end

  always_comb begin
    rev   = 1'b0;
    ea    = 1'b0;
    excl  = 1'b0;
    legal = is_load;
    case (ext)
      EXT_PLAIN: ;
      EXT_SWAP:  rev = 1'b1;
      EXT_ANDEA: begin
        ea = 1'b1;
        if (size == SZ_WORD) legal = 1'b0;
      end
      EXT_EXCL: begin
        excl = 1'b1;
        if (size != SZ_WORD) legal = 1'b0;
      end
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldfmt_agen.sv
module ldfmt_agen
  import ldfmt_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = $clog2(XLEN/8)
)(
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  input  lsize_e            size,
  input  logic              rev,
  input  logic              ea,
  output logic [XLEN-1:0]   addr,
  output logic [LANE_W-1:0] lane,
  output logic [XLEN/8-1:0] be
);
  localparam int NBYTE = XLEN/8;

  always_comb begin
    addr = ea ? (ra & rb) : (ra + rb);
    lane = '0;
    be   = '0;
    case (size)
      SZ_BYTE: begin
        lane = addr[LANE_W-1:0] ^ {LANE_W{rev}};
        be   = NBYTE'(1) << (NBYTE-1-int'(lane));
      end
      SZ_HALF: begin
        lane = {addr[LANE_W-1:1], 1'b0};
        be   = NBYTE'(3) << (NBYTE-2-int'(lane));
      end
      default: begin
        lane = '0;
        be   = '1;
      end
    endcase
  end
endmodule

// File: rtl/ldfmt_shape.sv
module ldfmt_shape
  import ldfmt_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = $clog2(XLEN/8)
)(
  input  logic [XLEN-1:0]   rdata,
  input  lsize_e            size,
  input  logic [LANE_W-1:0] lane,
  input  logic              rev,
  output logic [XLEN-1:0]   data
);
  localparam int NBYTE = XLEN/8;

  logic [XLEN-1:0] word_fmt;
  logic [XLEN-1:0] sh;
  logic [15:0]     half;

  for (genvar g = 0; g < NBYTE; g++) begin : g_swap
    assign word_fmt[8*g +: 8] = rev ? rdata[8*(NBYTE-1-g) +: 8] : rdata[8*g +: 8];
  end

  always_comb begin
    sh   = '0;
    half = '0;
    data = '0;
    case (size)
      SZ_BYTE: begin
        sh   = rdata >> (8*(NBYTE-1-int'(lane)));
        data = XLEN'(sh[7:0]);
      end
      SZ_HALF: begin
        sh   = rdata >> (8*(NBYTE-2-int'(lane)));
        half = rev ? {sh[7:0], sh[15:8]} : sh[15:0];
        data = XLEN'(half);
      end
      default: data = word_fmt;
    endcase
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  output logic                 issue_ready,
  input  logic [INSN_W-1:0]    instr,
  input  logic [XLEN-1:0]      ra_val,
  input  logic [XLEN-1:0]      rb_val,
  output logic                 mem_rd,
  output logic [XLEN-1:0]      mem_addr,
  output logic [XLEN/8-1:0]    mem_be,
  input  logic [XLEN-1:0]      mem_rdata,
  input  logic                 mem_rvalid,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_reg,
  output logic [XLEN-1:0]      wb_data,
  input  logic                 resv_clr,
  output logic                 resv,
  output logic                 illegal
);
  localparam int NBYTE  = XLEN/8;
  localparam int LANE_W = $clog2(NBYTE);

  logic                 d_legal, d_rev, d_ea, d_excl;
  lsize_e               d_size;
  logic [XLEN-1:0]      a_addr;
  logic [LANE_W-1:0]    a_lane;
  logic [NBYTE-1:0]     a_be;

  logic                 busy;
  logic                 accept;
  logic                 done;
  lsize_e               size_q;
  logic [LANE_W-1:0]    lane_q;
  logic                 rev_q;
  logic                 excl_q;
  logic [REG_IDX_W-1:0] rd_q;

  // operand index fields are resolved upstream; only the values arrive here
  logic unused_src_fields;
  assign unused_src_fields = ^instr[20:11];

  ldfmt_decode u_decode (
    .opcode (instr[31:26]),
    .ext    (instr[EXT_W-1:0]),
    .legal  (d_legal),
    .size   (d_size),
    .rev    (d_rev),
    .ea     (d_ea),
    .excl   (d_excl)
  );

  ldfmt_agen #(.XLEN(XLEN), .LANE_W(LANE_W)) u_agen (
    .ra   (ra_val),
    .rb   (rb_val),
    .size (d_size),
    .rev  (d_rev),
    .ea   (d_ea),
    .addr (a_addr),
    .lane (a_lane),
    .be   (a_be)
  );

  ldfmt_shape #(.XLEN(XLEN), .LANE_W(LANE_W)) u_shape (
    .rdata (mem_rdata),
    .size  (size_q),
    .lane  (lane_q),
    .rev   (rev_q),
    .data  (wb_data)
  );

  assign issue_ready = ~busy;
  assign accept      = issue_valid & ~busy;
  assign done        = busy & mem_rvalid;
  assign wb_en       = done;
  assign wb_reg      = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      mem_be   <= '0;
      illegal  <= 1'b0;
      size_q   <= SZ_WORD;
      lane_q   <= '0;
      rev_q    <= 1'b0;
      excl_q   <= 1'b0;
      rd_q     <= '0;
    end else begin
      mem_rd  <= 1'b0;
      illegal <= 1'b0;
      if (done) busy <= 1'b0;
      if (accept) begin
        if (d_legal) begin
          busy     <= 1'b1;
          mem_rd   <= 1'b1;
          mem_addr <= a_addr;
          mem_be   <= a_be;
          size_q   <= d_size;
          lane_q   <= a_lane;
          rev_q    <= d_rev;
          excl_q   <= d_excl;
          rd_q     <= instr[25:21];
        end else begin
          illegal  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                resv <= 1'b0;
    else if (resv_clr)      resv <= 1'b0;
    else if (done & excl_q) resv <= 1'b1;
  end
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
  parameter int XLEN = 32
)(
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic              mem_rd,
  input logic [XLEN/8-1:0] mem_be,
  input logic              wb_en,
  input logic              resv_clr,
  input logic              resv,
  input logic              illegal
);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_ready) |=> (mem_rd != illegal));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r2_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !issue_ready);

  a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == XLEN/8));

  a_r11_set_after_wb: assert property (@(posedge clk) disable iff (rst)
    $rose(resv) |-> $past(wb_en));

  a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
    resv_clr |=> !resv);

  a_r13_no_access: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!mem_rd && issue_ready && !wb_en));
endmodule

bind ldfmt_top ldfmt_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .mem_rd      (mem_rd),
  .mem_be      (mem_be),
  .wb_en       (wb_en),
  .resv_clr    (resv_clr),
  .resv        (resv),
  .illegal     (illegal)
);

// File: tb/test_ldfmt_top.sv
`timescale 1ns/1ps
module test_ldfmt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] instr = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] rb_val = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        wb_en;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  logic        resv_clr = 1'b0;
  logic        resv;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit exp_resv = 1'b0;

  always #5 clk = ~clk;

  ldfmt_top i_ldfmt_top (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .instr(instr), .ra_val(ra_val), .rb_val(rb_val), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .resv_clr(resv_clr), .resv(resv), .illegal(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rd,
                                     input logic [10:0] ext);
    return {opc, rd, 5'($urandom), 5'($urandom), ext};
  endfunction

  // Expected behaviour from the requirements
  task automatic model(input logic [31:0] ins, ra, rb, rdat,
                       output bit legal, output bit excl, output string req,
                       output logic [31:0] addr, output logic [3:0] be,
                       output logic [31:0] data);
    logic [5:0]  opc = ins[31:26];
    logic [10:0] ext = ins[10:0];
    logic [1:0]  ln;
    logic [15:0] h;
    bit rev = (ext == 11'h200);
    legal = 1'b1;
    excl  = 1'b0;
    req   = "R7";
    addr  = (ext == 11'h080) ? (ra & rb) : (ra + rb);
    be    = 4'hF;
    data  = rdat;
    if (!(ext == 11'h000 || ext == 11'h200 || ext == 11'h080 || ext == 11'h400)) legal = 1'b0;
    case (opc)
      6'b110000: begin
        if (ext == 11'h400) legal = 1'b0;
        ln   = addr[1:0] ^ (rev ? 2'd3 : 2'd0);
        be   = 4'b1000 >> ln;
        data = {24'h0, rdat[31-8*ln -: 8]};
        req  = rev ? "R8" : "R5";
      end
      6'b110001: begin
        if (ext == 11'h400) legal = 1'b0;
        be   = addr[1] ? 4'b0011 : 4'b1100;
        h    = addr[1] ? rdat[15:0] : rdat[31:16];
        if (rev) h = {h[7:0], h[15:8]};
        data = {16'h0, h};
        req  = rev ? "R9" : "R6";
      end
      6'b110010: begin
        if (ext == 11'h080) legal = 1'b0;
        if (rev) data = {rdat[7:0], rdat[15:8], rdat[23:16], rdat[31:24]};
        excl = (ext == 11'h400);
        req  = rev ? "R9" : (excl ? "R11" : "R7");
      end
      default: legal = 1'b0;
    endcase
  endtask

  task automatic do_load(input logic [31:0] ins, ra, rb, rdat, input int lat, input bit clr_wb);
    bit legal, excl;
    string req;
    logic [31:0] ea, dat;
    logic [3:0] be;
    model(ins, ra, rb, rdat, legal, excl, req, ea, be, dat);
    @(negedge clk);
    issue_valid = 1'b1; instr = ins; ra_val = ra; rb_val = rb;
    @(negedge clk);
    issue_valid = 1'b0; instr = $urandom; ra_val = $urandom; rb_val = $urandom;
    if (!legal) begin
      check("R13 illegal pulse", {31'h0, illegal}, 32'd1);
      check("R13 no read", {31'h0, mem_rd}, 32'd0);
      check("R13 still ready", {31'h0, issue_ready}, 32'd1);
      @(negedge clk);
      check("R13 single pulse", {31'h0, illegal}, 32'd0);
      return;
    end
    check("R2 read strobe", {31'h0, mem_rd}, 32'd1);
    check("R2 not ready", {31'h0, issue_ready}, 32'd0);
    check("R3 address", mem_addr, ea);
    check("R4 byte enables", {28'h0, mem_be}, {28'h0, be});
    for (int i = 0; i < lat; i++) begin
      mem_rdata = $urandom;
      @(negedge clk);
      check("R2 strobe one cycle", {31'h0, mem_rd}, 32'd0);
      check("R10 no early writeback", {31'h0, wb_en}, 32'd0);
    end
    mem_rvalid = 1'b1; mem_rdata = rdat; resv_clr = clr_wb;
    #1;
    check("R10 writeback enable", {31'h0, wb_en}, 32'd1);
    check("R10 writeback index", {27'h0, wb_reg}, {27'h0, ins[25:21]});
    check(req, wb_data, dat);
    @(negedge clk);
    mem_rvalid = 1'b0; resv_clr = 1'b0;
    if (clr_wb) exp_resv = 1'b0;
    else if (excl) exp_resv = 1'b1;
    check(clr_wb ? "R12 clear priority" : "R11 reservation", {31'h0, resv}, {31'h0, exp_resv});
    check("R2 ready after return", {31'h0, issue_ready}, 32'd1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] exts [4];
    logic [5:0]  opcs [4];
    void'($urandom(32'd4242));
    exts[0] = 11'h000; exts[1] = 11'h200; exts[2] = 11'h080; exts[3] = 11'h400;
    opcs[0] = 6'b110000; opcs[1] = 6'b110001; opcs[2] = 6'b110010; opcs[3] = 6'b010010;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, issue_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 read strobe", {31'h0, mem_rd}, 32'd0);
    check("R1 enables", {28'h0, mem_be}, 32'd0);
    check("R1 address", mem_addr, 32'd0);
    check("R1 illegal", {31'h0, illegal}, 32'd0);
    check("R1 writeback", {31'h0, wb_en}, 32'd0);
    check("R1 reservation", {31'h0, resv}, 32'd0);

    // byte lanes, plain and reversed
    for (int l = 0; l < 4; l++) begin
      do_load(mk(6'b110000, 5'd3, 11'h000), 32'h100, 32'(l), 32'h11223344, 0, 1'b0);
      do_load(mk(6'b110000, 5'd4, 11'h200), 32'h200, 32'(l), 32'hA1B2C3D4, 1, 1'b0);
    end
    // halfwords both lanes, plain and reversed
    do_load(mk(6'b110001, 5'd5, 11'h000), 32'h40, 32'h0, 32'hCAFEBEEF, 0, 1'b0);
    do_load(mk(6'b110001, 5'd6, 11'h000), 32'h40, 32'h2, 32'hCAFEBEEF, 2, 1'b0);
    do_load(mk(6'b110001, 5'd7, 11'h200), 32'h40, 32'h2, 32'hCAFEBEEF, 0, 1'b0);
    // words
    do_load(mk(6'b110010, 5'd8, 11'h000), 32'h1000, 32'h4, 32'h01234567, 0, 1'b0);
    do_load(mk(6'b110010, 5'd9, 11'h200), 32'h1000, 32'h4, 32'h01234567, 3, 1'b0);
    // AND addressing
    do_load(mk(6'b110000, 5'd10, 11'h080), 32'h0000_FFF3, 32'hFFFF_00F1, 32'h55667788, 0, 1'b0);
    do_load(mk(6'b110001, 5'd11, 11'h080), 32'hF0F0_F0F2, 32'h0FFF_FFFF, 32'h55667788, 1, 1'b0);
    // exclusive word then clear
    do_load(mk(6'b110010, 5'd12, 11'h400), 32'h80, 32'h8, 32'hDEADBEEF, 0, 1'b0);
    @(negedge clk); resv_clr = 1'b1;
    @(negedge clk); resv_clr = 1'b0; exp_resv = 1'b0;
    check("R12 clear", {31'h0, resv}, 32'd0);
    // clear in the same cycle as the exclusive writeback
    do_load(mk(6'b110010, 5'd13, 11'h400), 32'h80, 32'h8, 32'h12345678, 1, 1'b1);
    do_load(mk(6'b110010, 5'd14, 11'h400), 32'h80, 32'hC, 32'h9ABCDEF0, 0, 1'b0);
    // stray data valid while idle
    @(negedge clk); mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
    #1 check("R10 idle rvalid ignored", {31'h0, wb_en}, 32'd0);
    @(negedge clk); mem_rvalid = 1'b0;
    check("R10 idle rvalid keeps ready", {31'h0, issue_ready}, 32'd1);
    check("R10 idle rvalid keeps reservation", {31'h0, resv}, {31'h0, exp_resv});
    // illegal forms
    do_load(mk(6'b110010, 5'd15, 11'h080), 32'h4, 32'h4, 32'h0, 0, 1'b0);
    do_load(mk(6'b110000, 5'd16, 11'h400), 32'h4, 32'h4, 32'h0, 0, 1'b0);
    do_load(mk(6'b110001, 5'd17, 11'h001), 32'h4, 32'h4, 32'h0, 0, 1'b0);
    do_load(mk(6'b010010, 5'd18, 11'h000), 32'h4, 32'h4, 32'h0, 0, 1'b0);
    check("R13 reservation untouched", {31'h0, resv}, {31'h0, exp_resv});

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [10:0] e = (($urandom % 16) == 0) ? 11'($urandom) : exts[$urandom % 4];
      logic [5:0]  o = (($urandom % 12) == 0) ? opcs[3] : opcs[$urandom % 3];
      do_load(mk(o, 5'($urandom), e), $urandom, $urandom, $urandom,
              int'($urandom % 4), (($urandom % 8) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule